// File: doc/BRIEF.md
# Inter-Processor Command Mailbox

This block is a shared 128-word register window through which a host processor and a DSP exchange commands in both directions, with neither side in control of the other. The window has four 32-word blocks. The host-to-DSP command block sits at word address 0x80 and its reply block at 0xA0. The DSP-to-host command block sits at 0xC0 and its reply block at 0xE0. Each side has its own word-addressed port. A write takes effect at the next clock edge. A read is combinational.

In every block, word 0 holds the command or status and word 1 holds the count of valid payload words. Payload words run from word 2 to word 31, so a block carries at most 30 of them. A sender writes its payload and then its command word. That write marks the channel busy and sends an interrupt pulse to the receiver. The receiver clears the command word, fills in the reply block and writes a status word with the complete bit set. That write frees the channel and sends an interrupt pulse back to the sender. A second command issued while the channel is busy is thrown away and raises a sticky overrun flag.

Each channel is controlled by a two-state machine:
- IDLE: no command is outstanding. IDLE goes to BUSY (transition ISSUE) when the sender writes the command word.
- BUSY: a command is outstanding. BUSY goes to IDLE (transition FINISH) when the receiver writes a status word with bit 14 set.
- A sender command write while in BUSY (transition OVERRUN) keeps the state and sets the overrun flag.
- A bulk clear (transition FLUSH) returns either state to IDLE.

Top module: `ipc_mailbox`

## Requirements
- R1: Only word addresses 0x80 to 0xFF belong to the window. A read anywhere else returns 0, and a write anywhere else changes nothing.
- R2: Block bases are 0x80, 0xA0, 0xC0 and 0xE0. Word 1 of a block is its count and words 2 to 31 are its payload. A word written from one side reads back unchanged from both sides, apart from the effects of R3 and R4.
- R3: Payload word 2+k of a block reads as 0 whenever k is greater than or equal to the value held in word 1 of that block.
- R4: Command words (0x80 and 0xC0) keep only bits 11:0 of any write. Bits 15:12 always read as 0.
- R5: A command write by the sender while the channel is IDLE stores the word and sets busy in the following cycle. In that same cycle it raises a one-cycle pulse: irq_dsp_nmi for a host write to 0x80, or irq_host for a DSP write to 0xC0.
- R6: A receiver write to the status word (DSP to 0xA0, host to 0xE0) is always stored. If bit 14 is set (0x4000 = complete, which may be combined with 0x1000 = invalid command or 0x2000 = invalid parameters), busy clears in the next cycle and a one-cycle pulse is raised: irq_host for 0xA0, irq_dsp_int for 0xE0. Without bit 14 there is no pulse and busy is unchanged.
- R7: A sender command write while the channel is BUSY is dropped, so the command word keeps its old value and no pulse is raised. It sets that channel's overrun flag, which stays set until the sender pulses the channel's overrun-clear input.
- R8: A receiver write to the command word (to clear it) is stored. It changes neither busy nor any interrupt.
- R9: clr_all zeroes all 128 words, both busy flags and both overrun flags in the next cycle.
- R10: When both sides write the same word in the same cycle, the host data is kept and the DSP write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_all | input | 1 | Bulk clear of window and channel state |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | 8 | Host word address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data |
| dsp_we | input | 1 | DSP write strobe |
| dsp_addr | input | 8 | DSP word address |
| dsp_wdata | input | 16 | DSP write data |
| dsp_rdata | output | 16 | DSP read data |
| h2d_ovr_clr | input | 1 | Host clears host-to-DSP overrun |
| d2h_ovr_clr | input | 1 | DSP clears DSP-to-host overrun |
| h2d_busy | output | 1 | Host-to-DSP command outstanding |
| d2h_busy | output | 1 | DSP-to-host command outstanding |
| h2d_ovr | output | 1 | Host-to-DSP overrun flag |
| d2h_ovr | output | 1 | DSP-to-host overrun flag |
| irq_dsp_nmi | output | 1 | Non-maskable interrupt pulse to DSP |
| irq_dsp_int | output | 1 | Maskable interrupt pulse to DSP |
| irq_host | output | 1 | Interrupt pulse to host |

## Verification
Read data depends combinationally on the stored words, so a value written at one clock edge can be read back in the half cycle that follows it. Busy, overrun and every interrupt pulse come from registers updated at the same edge that stores the write. These are therefore due one cycle after the write is presented. Each pulse must be back at 0 one cycle later. The bench drives every input on the falling edge. It samples right after the falling edge that follows the write edge, and again one cycle later to confirm that each pulse lasts exactly one cycle.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_BUSY = 1'b1
    } ch_state_e;

    localparam int unsigned CMD_CODE_BITS = 12;
    localparam int unsigned DONE_BIT      = 14;

    localparam logic [15:0] STAT_DONE      = 16'h4000;
    localparam logic [15:0] STAT_OK        = 16'h0000;
    localparam logic [15:0] STAT_BAD_CMD   = 16'h1000;
    localparam logic [15:0] STAT_BAD_PARAM = 16'h2000;

    localparam int unsigned PAYLOAD_FIRST = 2;

endpackage

// File: rtl/ipc_chan_fsm.sv
module ipc_chan_fsm
    import ipc_mailbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic issue,
    input  logic finish,
    input  logic ovr_clr,
    output logic accept,
    output logic busy,
    output logic ovr,
    output logic issue_pulse,
    output logic finish_pulse
);

    ch_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (issue)  state_d = CH_BUSY;
            CH_BUSY: if (finish) state_d = CH_IDLE;
        endcase
        if (flush) state_d = CH_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    assign busy   = (state_q == CH_BUSY);
    assign accept = issue && (state_q == CH_IDLE) && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_pulse  <= 1'b0;
            finish_pulse <= 1'b0;
            ovr          <= 1'b0;
        end else if (flush) begin
            issue_pulse  <= 1'b0;
            finish_pulse <= 1'b0;
            ovr          <= 1'b0;
        end else begin
            issue_pulse  <= accept;
            finish_pulse <= finish;
            if (issue && (state_q == CH_BUSY)) ovr <= 1'b1;
            else if (ovr_clr)                  ovr <= 1'b0;
        end
    end

endmodule

// File: rtl/ipc_window_ram.sv
module ipc_window_ram
    import ipc_mailbox_pkg::*;
#(
    parameter int unsigned DW        = 16,
    parameter int unsigned BLK_WORDS = 32,
    parameter int unsigned NBLK      = 4,
    localparam int unsigned DEPTH    = BLK_WORDS * NBLK,
    localparam int unsigned IW       = $clog2(DEPTH),
    localparam int unsigned BW       = $clog2(BLK_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 wa_en,
    input  logic [IW-1:0]        wa_addr,
    input  logic [DW-1:0]        wa_data,
    input  logic                 wb_en,
    input  logic [IW-1:0]        wb_addr,
    input  logic [DW-1:0]        wb_data,
    input  logic [1:0][IW-1:0]   rd_addr,
    output logic [1:0][DW-1:0]   rd_data
);

    logic [DW-1:0] mem [DEPTH];

    // port a is written last so it wins on a shared address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (flush) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (wb_en) mem[wb_addr] <= wb_data;
            if (wa_en) mem[wa_addr] <= wa_data;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        logic [IW-1:0] cnt_addr;
        logic [BW-1:0] word;
        logic [DW-1:0] slot;
        logic          beyond;
        always_comb begin
            word     = rd_addr[p][BW-1:0];
            cnt_addr = {rd_addr[p][IW-1:BW], BW'(1)};
            slot     = DW'(word) - DW'(PAYLOAD_FIRST);
            beyond   = (word >= BW'(PAYLOAD_FIRST)) && (slot >= mem[cnt_addr]);
            rd_data[p] = beyond ? '0 : mem[rd_addr[p]];
        end
    end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mailbox_pkg::*;
#(
    parameter int unsigned DW        = 16,
    parameter int unsigned AW        = 8,
    parameter int unsigned BLK_WORDS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          hst_we,
    input  logic [AW-1:0] hst_addr,
    input  logic [DW-1:0] hst_wdata,
    output logic [DW-1:0] hst_rdata,
    input  logic          dsp_we,
    input  logic [AW-1:0] dsp_addr,
    input  logic [DW-1:0] dsp_wdata,
    output logic [DW-1:0] dsp_rdata,
    input  logic          h2d_ovr_clr,
    input  logic          d2h_ovr_clr,
    output logic          h2d_busy,
    output logic          d2h_busy,
    output logic          h2d_ovr,
    output logic          d2h_ovr,
    output logic          irq_dsp_nmi,
    output logic          irq_dsp_int,
    output logic          irq_host
);

    localparam int unsigned NBLK = 4;
    localparam int unsigned IW   = $clog2(BLK_WORDS * NBLK);
    localparam int unsigned BW   = $clog2(BLK_WORDS);
    localparam logic [DW-1:0] CODE_MASK = DW'((1 << CMD_CODE_BITS) - 1);

    logic [IW-1:0] off_h, off_d;
    logic          win_h, win_d, hit_h, hit_d, same_word;

    assign off_h = hst_addr[IW-1:0];
    assign off_d = dsp_addr[IW-1:0];
    assign win_h = (hst_addr[AW-1:IW] == (AW-IW)'(1));
    assign win_d = (dsp_addr[AW-1:IW] == (AW-IW)'(1));
    assign hit_h = hst_we && win_h;
    assign same_word = hit_h && (off_h == off_d);
    assign hit_d = dsp_we && win_d && !same_word;

    logic [1:0] issue, finish, accept, busy, ovr, ipulse, fpulse, oclr;
    assign oclr = {d2h_ovr_clr, h2d_ovr_clr};

    for (genvar c = 0; c < 2; c++) begin : g_ch
        localparam logic [IW-1:0] CMD_OFF  = IW'((2*c)   * BLK_WORDS);
        localparam logic [IW-1:0] STAT_OFF = IW'((2*c+1) * BLK_WORDS);
        if (c == 0) begin : g_h2d
            assign issue[c]  = hit_h && (off_h == CMD_OFF);
            assign finish[c] = hit_d && (off_d == STAT_OFF) && dsp_wdata[DONE_BIT];
        end else begin : g_d2h
            assign issue[c]  = hit_d && (off_d == CMD_OFF);
            assign finish[c] = hit_h && (off_h == STAT_OFF) && hst_wdata[DONE_BIT];
        end
        ipc_chan_fsm i_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .flush        (clr_all),
            .issue        (issue[c]),
            .finish       (finish[c]),
            .ovr_clr      (oclr[c]),
            .accept       (accept[c]),
            .busy         (busy[c]),
            .ovr          (ovr[c]),
            .issue_pulse  (ipulse[c]),
            .finish_pulse (fpulse[c])
        );
    end

    // command words sit in the even blocks, word 0
    logic          cmd_h, cmd_d, wen_h, wen_d;
    logic [DW-1:0] data_h, data_d;
    assign cmd_h  = (off_h[BW-1:0] == '0) && !off_h[BW];
    assign cmd_d  = (off_d[BW-1:0] == '0) && !off_d[BW];
    assign data_h = cmd_h ? (hst_wdata & CODE_MASK) : hst_wdata;
    assign data_d = cmd_d ? (dsp_wdata & CODE_MASK) : dsp_wdata;
    assign wen_h  = hit_h && !(issue[0] && !accept[0]);
    assign wen_d  = hit_d && !(issue[1] && !accept[1]);

    logic [1:0][DW-1:0] rd_data;

    ipc_window_ram #(
        .DW        (DW),
        .BLK_WORDS (BLK_WORDS),
        .NBLK      (NBLK)
    ) i_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (clr_all),
        .wa_en   (wen_h),
        .wa_addr (off_h),
        .wa_data (data_h),
        .wb_en   (wen_d),
        .wb_addr (off_d),
        .wb_data (data_d),
        .rd_addr ({off_d, off_h}),
        .rd_data (rd_data)
    );

    assign hst_rdata   = win_h ? rd_data[0] : '0;
    assign dsp_rdata   = win_d ? rd_data[1] : '0;
    assign h2d_busy    = busy[0];
    assign d2h_busy    = busy[1];
    assign h2d_ovr     = ovr[0];
    assign d2h_ovr     = ovr[1];
    assign irq_dsp_nmi = ipulse[0];
    assign irq_dsp_int = fpulse[1];
    assign irq_host    = fpulse[0] | ipulse[1];

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_all,
    input logic [AW-1:0] hst_addr,
    input logic [DW-1:0] hst_rdata,
    input logic          h2d_busy,
    input logic          d2h_busy,
    input logic          h2d_ovr,
    input logic          d2h_ovr,
    input logic          irq_dsp_nmi,
    input logic          irq_dsp_int,
    input logic          irq_host
);

    localparam logic [AW-1:0] H2D_CMD = AW'(1 << (AW-1));

    assert_outside_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_addr[AW-1] |-> (hst_rdata == '0));

    assert_cmd_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_addr == H2D_CMD) |-> (hst_rdata[DW-1:12] == '0));

    assert_nmi_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dsp_nmi |=> !irq_dsp_nmi);

    assert_h2d_issue_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h2d_busy) |-> irq_dsp_nmi);

    assert_d2h_issue_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d2h_busy) |-> irq_host);

    assert_finish_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_dsp_int && $past(d2h_busy)) |-> !d2h_busy);

    assert_ovr_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h2d_ovr) |-> $past(h2d_busy));

    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (!h2d_busy && !d2h_busy && !h2d_ovr && !d2h_ovr));

endmodule

bind ipc_mailbox ipc_mailbox_chk #(.DW(DW), .AW(AW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_all     (clr_all),
    .hst_addr    (hst_addr),
    .hst_rdata   (hst_rdata),
    .h2d_busy    (h2d_busy),
    .d2h_busy    (d2h_busy),
    .h2d_ovr     (h2d_ovr),
    .d2h_ovr     (d2h_ovr),
    .irq_dsp_nmi (irq_dsp_nmi),
    .irq_dsp_int (irq_dsp_int),
    .irq_host    (irq_host)
);

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_all = 1'b0;
    logic        hst_we = 1'b0, dsp_we = 1'b0;
    logic [7:0]  hst_addr = '0, dsp_addr = '0;
    logic [15:0] hst_wdata = '0, dsp_wdata = '0;
    logic [15:0] hst_rdata, dsp_rdata;
    logic        h2d_ovr_clr = 1'b0, d2h_ovr_clr = 1'b0;
    logic        h2d_busy, d2h_busy, h2d_ovr, d2h_ovr;
    logic        irq_dsp_nmi, irq_dsp_int, irq_host;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipc_mailbox i_ipc_mailbox (
        .clk (clk), .rst_n (rst_n), .clr_all (clr_all),
        .hst_we (hst_we), .hst_addr (hst_addr), .hst_wdata (hst_wdata), .hst_rdata (hst_rdata),
        .dsp_we (dsp_we), .dsp_addr (dsp_addr), .dsp_wdata (dsp_wdata), .dsp_rdata (dsp_rdata),
        .h2d_ovr_clr (h2d_ovr_clr), .d2h_ovr_clr (d2h_ovr_clr),
        .h2d_busy (h2d_busy), .d2h_busy (d2h_busy), .h2d_ovr (h2d_ovr), .d2h_ovr (d2h_ovr),
        .irq_dsp_nmi (irq_dsp_nmi), .irq_dsp_int (irq_dsp_int), .irq_host (irq_host)
    );

    // {host side, address, write data, expected read}
    localparam int NVEC = 10;
    localparam logic [63:0] VEC [NVEC] = '{
        {16'd1, 16'h0081, 16'h0003, 16'h0003},   // R2 count word
        {16'd1, 16'h0082, 16'h1111, 16'h1111},   // R2 payload slot 0
        {16'd1, 16'h0084, 16'h3333, 16'h3333},   // R3 slot 2 < 3
        {16'd1, 16'h0085, 16'h4444, 16'h0000},   // R3 slot 3 >= 3
        {16'd0, 16'h00C1, 16'h001E, 16'h001E},   // R2 count 30
        {16'd0, 16'h00DF, 16'hBEEF, 16'hBEEF},   // R3 slot 29 < 30
        {16'd1, 16'h0040, 16'h1234, 16'h0000},   // R1 outside window
        {16'd0, 16'h00E3, 16'h5555, 16'h0000},   // R3 count 0
        {16'd1, 16'h00E1, 16'h0002, 16'h0002},   // R2 reply count
        {16'd0, 16'h00A2, 16'h7777, 16'h0000}    // R3 reply count 0
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // returns at the falling edge after the write edge
    task automatic wr(input bit host, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        if (host) begin hst_we = 1'b1; hst_addr = a; hst_wdata = d; end
        else      begin dsp_we = 1'b1; dsp_addr = a; dsp_wdata = d; end
        @(negedge clk);
        hst_we = 1'b0;
        dsp_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag, input logic [15:0] exp);
        hst_addr = a;
        dsp_addr = a;
        #1;
        chk({tag, " host"}, hst_rdata, exp);
        chk({tag, " dsp"}, dsp_rdata, exp);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R9 reset h2d_busy", 16'(h2d_busy), 16'd0);
        chk("R9 reset d2h_ovr", 16'(d2h_ovr), 16'd0);
        chk("R5 reset irq_host", 16'(irq_host), 16'd0);
        rd(8'h80, "R2 reset cmd", 16'h0000);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][48], VEC[i][39:32], VEC[i][31:16]);
            rd(VEC[i][39:32], $sformatf("R2/R3/R1 vec%0d", i), VEC[i][15:0]);
        end

        // R5/R4: host issues, upper bits dropped
        wr(1'b1, 8'h80, 16'hF123);
        chk("R5 nmi pulse", 16'(irq_dsp_nmi), 16'd1);
        chk("R5 h2d busy", 16'(h2d_busy), 16'd1);
        chk("R5 no host irq", 16'(irq_host), 16'd0);
        rd(8'h80, "R4 masked cmd", 16'h0123);
        @(negedge clk);
        chk("R5 nmi one cycle", 16'(irq_dsp_nmi), 16'd0);

        // R7: second issue while busy
        wr(1'b1, 8'h80, 16'h0456);
        chk("R7 overrun set", 16'(h2d_ovr), 16'd1);
        chk("R7 no nmi", 16'(irq_dsp_nmi), 16'd0);
        rd(8'h80, "R7 cmd kept", 16'h0123);

        // R8: receiver clears command word
        wr(1'b0, 8'h80, 16'h0000);
        chk("R8 busy kept", 16'(h2d_busy), 16'd1);
        chk("R8 no irq", 16'(irq_host), 16'd0);
        rd(8'h80, "R8 cmd cleared", 16'h0000);

        // R6: status without complete bit
        wr(1'b0, 8'hA0, 16'h1000);
        chk("R6 no pulse", 16'(irq_host), 16'd0);
        chk("R6 still busy", 16'(h2d_busy), 16'd1);
        rd(8'hA0, "R6 status stored", 16'h1000);

        // R6: complete with invalid-parameter code
        wr(1'b0, 8'hA0, 16'h6000);
        chk("R6 host irq", 16'(irq_host), 16'd1);
        chk("R6 busy freed", 16'(h2d_busy), 16'd0);
        chk("R7 overrun sticky", 16'(h2d_ovr), 16'd1);
        @(negedge clk);
        chk("R6 irq one cycle", 16'(irq_host), 16'd0);

        // R7: overrun clear
        h2d_ovr_clr = 1'b1;
        @(negedge clk);
        h2d_ovr_clr = 1'b0;
        chk("R7 overrun cleared", 16'(h2d_ovr), 16'd0);

        // R5 reverse channel
        wr(1'b0, 8'hC0, 16'hA0BC);
        chk("R5 d2h host irq", 16'(irq_host), 16'd1);
        chk("R5 d2h busy", 16'(d2h_busy), 16'd1);
        chk("R5 d2h no nmi", 16'(irq_dsp_nmi), 16'd0);
        rd(8'hC0, "R4 d2h masked", 16'h00BC);

        // R6 reverse completion
        wr(1'b1, 8'hE0, 16'h4000);
        chk("R6 dsp int", 16'(irq_dsp_int), 16'd1);
        chk("R6 d2h freed", 16'(d2h_busy), 16'd0);
        chk("R6 no nmi", 16'(irq_dsp_nmi), 16'd0);

        // R10: same-word collision, host wins
        @(negedge clk);
        hst_we = 1'b1; hst_addr = 8'h83; hst_wdata = 16'hAAAA;
        dsp_we = 1'b1; dsp_addr = 8'h83; dsp_wdata = 16'h5555;
        @(negedge clk);
        hst_we = 1'b0; dsp_we = 1'b0;
        rd(8'h83, "R10 host wins", 16'hAAAA);

        // R9: bulk clear with busy and overrun pending
        wr(1'b1, 8'h80, 16'h0001);
        wr(1'b1, 8'h80, 16'h0002);
        chk("R9 pre ovr", 16'(h2d_ovr), 16'd1);
        clr_all = 1'b1;
        @(negedge clk);
        clr_all = 1'b0;
        chk("R9 busy cleared", 16'(h2d_busy), 16'd0);
        chk("R9 ovr cleared", 16'(h2d_ovr), 16'd0);
        rd(8'h81, "R9 count zero", 16'h0000);
        rd(8'hC1, "R9 d2h count zero", 16'h0000);
        rd(8'h80, "R9 cmd zero", 16'h0000);

        finish_run();
    end

endmodule